// File: doc/BRIEF.md
# Mode-Dependent Address Extension Unit

This unit forms the 24-bit physical address for every memory access of a processor that runs in one of two modes. In the short (legacy) mode, program code produces 16-bit addresses. The unit places an 8-bit window-base value above them, so each legacy program lives inside a 64 KB window that the base selects. Several such programs can sit side by side in the 16 MB space, each with its own base value. In the long (flat) mode, the full 24-bit logical address reaches the bus unchanged.

The window base can only be written while the long mode is in force. Legacy code therefore cannot move its own window. A one-shot prefix from the instruction decoder can force short or long addressing for a single instruction. The prefix then lapses when that instruction completes.

The mode bit is held in a register that software loads through a dedicated strobe. Both the mode register and the window base are reset to short mode with base zero.

Top module: `addr_ext_unit`

## Requirements
- R1: After reset the unit is in short mode with window base 0 and no prefix pending, so the output is {8'h00, logical[15:0]}.
- R2: In short mode the output is {base, logical[15:0]}. Logical bits 23:16 have no effect, and 16-bit addresses wrap inside the window without carrying into bit 16.
- R3: In long mode the output equals the 24-bit logical address.
- R4: A base write while the mode register holds long mode changes the base, and the new value is used from the next clock cycle.
- R5: A base write while the mode register holds short mode is ignored, and the base keeps its old value.
- R6: When pfx_valid_i is high, a prefix is recorded. Bit 0 of pfx_code_i selects long (1) or short (0) addressing. Bit 1 (data width) has no effect on the address. The override governs the output from the next cycle, regardless of the mode register.
- R7: A recorded prefix is dropped after the cycle in which instr_done_i is high. If pfx_valid_i is high in that same cycle, the new prefix is recorded instead.
- R8: mode_load_i loads mode_val_i (1 = long) into the mode register, effective next cycle. A base write in the same cycle is judged by the mode held before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load_i | input | 1 | Load the mode register |
| mode_val_i | input | 1 | Mode to load, 1 = long |
| pfx_valid_i | input | 1 | Prefix decoded this cycle |
| pfx_code_i | input | 2 | Prefix selection: bit 0 address long, bit 1 data long |
| instr_done_i | input | 1 | Current instruction completes this cycle |
| base_wr_i | input | 1 | Window-base write request |
| base_wdata_i | input | 8 | Window-base write value |
| logic_addr_i | input | 24 | Logical address from the core |
| phys_addr_o | output | 24 | Physical address to the bus |

## Verification
On every cycle, the assertions check the following:
- the low 16 bits always pass through;
- the upper byte equals the window base whenever addressing is short;
- the output is flat whenever addressing is long;
- a short-mode write never disturbs the base;
- a long-mode write lands one cycle later;
- a completed instruction without a new prefix leaves no override.

The bench scenarios are what show the following:
- that every base value from 0 to 255 really selects its own window;
- that the upper logical byte is ignored in short mode;
- that the ordering works when a mode load and a base write coincide;
- that a prefix arriving in the same cycle as completion survives.

// File: rtl/addr_ext_pkg.sv
package addr_ext_pkg;
    localparam int unsigned PHYS_W  = 24;
    localparam int unsigned SHORT_W = 16;
    localparam int unsigned BASE_W  = PHYS_W - SHORT_W;

    typedef struct packed {
        logic mode_long;
        logic pfx_act;
        logic pfx_long;
    } ctrl_state_t;
endpackage

// File: rtl/aeu_ctrl.sv
module aeu_ctrl
    import addr_ext_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_load_i,
    input  logic       mode_val_i,
    input  logic       pfx_valid_i,
    input  logic [1:0] pfx_code_i,
    input  logic       instr_done_i,
    output logic       mode_long_o,
    output logic       pfx_act_o,
    output logic       long_eff_o
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_load_i) begin
            st_d.mode_long = mode_val_i;
        end
        // a fresh prefix wins over expiry of the previous one
        if (pfx_valid_i) begin
            st_d.pfx_act  = 1'b1;
            st_d.pfx_long = pfx_code_i[0];
        end else if (instr_done_i) begin
            st_d.pfx_act  = 1'b0;
            st_d.pfx_long = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_long_o = st_q.mode_long;
    assign pfx_act_o   = st_q.pfx_act;
    assign long_eff_o  = st_q.pfx_act ? st_q.pfx_long : st_q.mode_long;
endmodule

// File: rtl/aeu_base_reg.sv
module aeu_base_reg
    import addr_ext_pkg::*;
#(
    parameter int unsigned BW = BASE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          priv_i,
    input  logic          wr_i,
    input  logic [BW-1:0] wdata_i,
    output logic [BW-1:0] base_o
);
    logic [BW-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (wr_i && priv_i) begin
            base_d = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    assign base_o = base_q;
endmodule

// File: rtl/aeu_addr_mux.sv
module aeu_addr_mux #(
    parameter int unsigned PW = 24,
    parameter int unsigned SW = 16
) (
    input  logic             long_i,
    input  logic [PW-SW-1:0] base_i,
    input  logic [PW-1:0]    logic_i,
    output logic [PW-1:0]    phys_o
);
    always_comb begin
        if (long_i) begin
            phys_o = logic_i;
        end else begin
            phys_o = {base_i, logic_i[SW-1:0]};
        end
    end
endmodule

// File: rtl/addr_ext_unit.sv
module addr_ext_unit
    import addr_ext_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load_i,
    input  logic              mode_val_i,
    input  logic              pfx_valid_i,
    input  logic [1:0]        pfx_code_i,
    input  logic              instr_done_i,
    input  logic              base_wr_i,
    input  logic [BASE_W-1:0] base_wdata_i,
    input  logic [PHYS_W-1:0] logic_addr_i,
    output logic [PHYS_W-1:0] phys_addr_o
);
    logic              mode_long;
    logic              pfx_act;
    logic              long_eff;
    logic [BASE_W-1:0] base;

    aeu_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_load_i  (mode_load_i),
        .mode_val_i   (mode_val_i),
        .pfx_valid_i  (pfx_valid_i),
        .pfx_code_i   (pfx_code_i),
        .instr_done_i (instr_done_i),
        .mode_long_o  (mode_long),
        .pfx_act_o    (pfx_act),
        .long_eff_o   (long_eff)
    );

    aeu_base_reg #(.BW(BASE_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .priv_i  (mode_long),
        .wr_i    (base_wr_i),
        .wdata_i (base_wdata_i),
        .base_o  (base)
    );

    aeu_addr_mux #(.PW(PHYS_W), .SW(SHORT_W)) u_mux (
        .long_i  (long_eff),
        .base_i  (base),
        .logic_i (logic_addr_i),
        .phys_o  (phys_addr_o)
    );
endmodule

// File: rtl/addr_ext_unit_chk.sv
module addr_ext_unit_chk
    import addr_ext_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_long,
    input logic              long_eff,
    input logic              pfx_act,
    input logic              pfx_valid_i,
    input logic              instr_done_i,
    input logic              base_wr_i,
    input logic [BASE_W-1:0] base_wdata_i,
    input logic [BASE_W-1:0] base,
    input logic [PHYS_W-1:0] logic_addr_i,
    input logic [PHYS_W-1:0] phys_addr_o
);
    AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr_o[SHORT_W-1:0] == logic_addr_i[SHORT_W-1:0]); // R2

    AST_SHORT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !long_eff |-> phys_addr_o[PHYS_W-1:SHORT_W] == base); // R2

    AST_LONG_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        long_eff |-> phys_addr_o == logic_addr_i); // R3

    AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr_i && mode_long) |=> base == $past(base_wdata_i)); // R4

    AST_BASE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr_i && !mode_long) |=> $stable(base)); // R5

    AST_PFX_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done_i && !pfx_valid_i) |=> !pfx_act); // R7

    AST_PFX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_valid_i |=> pfx_act); // R6
endmodule

bind addr_ext_unit addr_ext_unit_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_long    (mode_long),
    .long_eff     (long_eff),
    .pfx_act      (pfx_act),
    .pfx_valid_i  (pfx_valid_i),
    .instr_done_i (instr_done_i),
    .base_wr_i    (base_wr_i),
    .base_wdata_i (base_wdata_i),
    .base         (base),
    .logic_addr_i (logic_addr_i),
    .phys_addr_o  (phys_addr_o)
);

// File: tb/test_addr_ext_unit.sv
module test_addr_ext_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load_i = 1'b0;
    logic        mode_val_i = 1'b0;
    logic        pfx_valid_i = 1'b0;
    logic [1:0]  pfx_code_i = 2'b00;
    logic        instr_done_i = 1'b0;
    logic        base_wr_i = 1'b0;
    logic [7:0]  base_wdata_i = 8'h00;
    logic [23:0] logic_addr_i = 24'h0;
    logic [23:0] phys_addr_o;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model
    logic [7:0] m_base  = 8'h00;
    logic       m_mode  = 1'b0;
    logic       m_pact  = 1'b0;
    logic       m_plong = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    addr_ext_unit i_addr_ext_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_load_i  (mode_load_i),
        .mode_val_i   (mode_val_i),
        .pfx_valid_i  (pfx_valid_i),
        .pfx_code_i   (pfx_code_i),
        .instr_done_i (instr_done_i),
        .base_wr_i    (base_wr_i),
        .base_wdata_i (base_wdata_i),
        .logic_addr_i (logic_addr_i),
        .phys_addr_o  (phys_addr_o)
    );

    task automatic tick(input logic bw, input logic [7:0] bd, input logic ml,
                        input logic mv, input logic pv, input logic [1:0] pc,
                        input logic dn);
        base_wr_i = bw; base_wdata_i = bd; mode_load_i = ml; mode_val_i = mv;
        pfx_valid_i = pv; pfx_code_i = pc; instr_done_i = dn;
        @(posedge clk);
        if (bw && m_mode) m_base = bd;
        if (ml) m_mode = mv;
        if (pv) begin m_pact = 1'b1; m_plong = pc[0]; end
        else if (dn) begin m_pact = 1'b0; m_plong = 1'b0; end
        #1;
        base_wr_i = 1'b0; mode_load_i = 1'b0; pfx_valid_i = 1'b0; instr_done_i = 1'b0;
    endtask

    task automatic probe(input logic [23:0] a, input string req);
        logic [23:0] exp;
        logic        lng;
        logic_addr_i = a;
        #1;
        lng = m_pact ? m_plong : m_mode;
        exp = lng ? a : {m_base, a[15:0]};
        n_chk++;
        if (phys_addr_o !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, phys_addr_o, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        probe(24'hAB1234, "R1");
        probe(24'hFFFFFF, "R1");
        // R5 write refused in short mode
        tick(1, 8'h5A, 0, 0, 0, 2'b00, 0);
        probe(24'h00CAFE, "R5");
        // R8 mode load plus write same cycle: judged by old short mode
        tick(1, 8'h33, 1, 1, 0, 2'b00, 0);
        probe(24'h123456, "R8");
        // R3 flat sweep
        for (int i = 0; i < 256; i++) probe(24'(i * 65793 + 7), "R3");
        // R4 and R2: every base, checked through a short prefix
        for (int b = 0; b < 256; b++) begin
            tick(1, 8'(b), 0, 0, 1, 2'b10, 0);
            probe(24'(b * 4099) ^ 24'hFF0000, "R4");
            probe(24'h00FFFF, "R2");
            tick(0, 8'h00, 0, 0, 0, 2'b00, 1);
            probe(24'h7E0001, "R7");
        end
        // back to short mode, base = 0xC3
        tick(1, 8'hC3, 1, 0, 0, 2'b00, 0);
        for (int h = 0; h < 256; h += 15) probe({8'(h), 16'hFFFF}, "R2");
        tick(1, 8'h11, 0, 0, 0, 2'b00, 0);
        probe(24'h990000, "R5");
        // R6 long prefix in short mode, data bit ignored
        tick(0, 8'h00, 0, 0, 1, 2'b11, 0);
        probe(24'hA5A5A5, "R6");
        tick(0, 8'h00, 0, 0, 0, 2'b00, 0);
        probe(24'h5A5A5A, "R6");
        // R7 done together with a fresh short prefix: new one kept
        tick(0, 8'h00, 0, 0, 1, 2'b00, 1);
        probe(24'h445566, "R7");
        // R7 fresh long prefix on completion, then expiry
        tick(0, 8'h00, 0, 0, 1, 2'b01, 1);
        probe(24'h445566, "R7");
        tick(0, 8'h00, 0, 0, 0, 2'b00, 1);
        probe(24'h445566, "R7");
        // R1 reset again restores base and mode
        rst_n = 1'b0;
        @(posedge clk);
        m_base = 8'h00; m_mode = 1'b0; m_pact = 1'b0; m_plong = 1'b0;
        #1 rst_n = 1'b1;
        probe(24'hFEDCBA, "R1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule